// File: doc/BRIEF.md
# Timer Interrupt Flag and Status Unit

This block holds the interrupt bookkeeping for a general-purpose timer with four capture/compare channels. The timer core sends it single-cycle event strobes:
- per-channel capture or compare events;
- counter overflow;
- a software overflow request;
- a counter reinitialisation caused by a trigger;
- a per-channel strobe for a read of the capture data register.

It also receives the level of the trigger input and finds its edges itself. Each source latches into a sticky status flag. Software clears a flag by writing a zero to its bit. A read of a capture-mode channel's data register also clears that channel's flag.

A second flag per channel records an overcapture: a capture that arrives while the channel's flag is still pending. A separate enable word gates the event, overflow and trigger flags onto one interrupt request line. The overcapture flags are status-only and never reach that line.

Software reaches both words through a simple register bus. Address 0 is the status word and address 1 is the enable word. The bus accepts a write or a read in every cycle and never stalls, so there is no back-pressure. Read data returns one cycle after the read strobe.

Top module: `tmr_irq_status`

## Requirements
- R1: After reset, every status flag, every enable bit, `bus_rdata` and `irq` are 0.
- R2: Status bits 5, 7, 8 and 13 to 15 always read 0 and ignore writes. Enable bits 5 and 7 to 15 always read 0, so writing 0xFFFF to the enable word reads back 0x005F.
- R3: Writing the status word (address 0) clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R4: A channel event strobe on channel n (n = 0..3) sets status bit 1+n, whatever mode the channel is in. The flag is visible from the next clock edge.
- R5: A data-read strobe on a channel in capture mode (`ch_capture_mode` bit = 1) clears its event flag. On a channel in compare mode the strobe has no effect.
- R6: On a channel in capture mode, an event that arrives while its event flag is already 1 sets overcapture flag 9+n. This does not happen if the event flag is being cleared in the same cycle, by a data read or by a software zero write; the event flag then stays set. A compare-mode channel never sets its overcapture flag.
- R7: Trigger flag bit 6 is set on a rising edge of `trig_in` when `trig_falling` = 0, and on a falling edge when `trig_falling` = 1. When `trig_suspend` = 1 it is set on either edge.
- R8: Overflow flag bit 0 is set by `ovf_evt` in every case. It is set by `sw_ovf_req` or `trig_reinit` only when `ovf_gen_en` = 1 and `ovf_src_restrict` = 0.
- R9: If a hardware set and a software zero write hit the same flag in one cycle, the flag ends up set.
- R10: `irq` is 1 exactly when some flag among bits 0 to 4 and 6 is 1 and its enable bit (same position in the enable word) is 1. The overcapture flags never raise `irq`.
- R11: `bus_rdata` shows the addressed word, taken before that cycle's updates, one cycle after `bus_rd`. Address 0 returns status, address 1 returns enable, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| ch_evt | input | NUM_CH (4) | Per-channel capture/compare event pulse |
| ch_dat_rd | input | NUM_CH (4) | Per-channel capture data register read pulse |
| ch_capture_mode | input | NUM_CH (4) | 1 = capture (input) mode, 0 = compare (output) mode |
| ovf_evt | input | 1 | Counter overflow pulse |
| sw_ovf_req | input | 1 | Software overflow request pulse |
| trig_reinit | input | 1 | Counter reinitialised by trigger, pulse |
| ovf_gen_en | input | 1 | Overflow event generation enabled |
| ovf_src_restrict | input | 1 | 1 = only real counter overflow may set the flag |
| trig_in | input | 1 | Trigger input level |
| trig_falling | input | 1 | Active trigger edge: 0 rising, 1 falling |
| trig_suspend | input | 1 | Suspend mode: any trigger edge counts |
| irq | output | 1 | Combined interrupt request |

## Verification
Strobes sampled at a clock edge set or clear their flags at that same edge. `irq` follows the flags combinationally, so it is due in the same cycle as the flag. A read strobe puts the pre-update word on `bus_rdata` at the following edge.

A trigger level change is seen at the first edge that samples the new level, and the flag is set there. The bench drives every input on the falling clock edge and samples on the falling edge. Its behavioural model advances at each rising edge and is compared with `irq` and `bus_rdata` every cycle. Directed reads check each status pattern one cycle after the stimulus that produced it.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int STS_W   = 16;
  localparam int NUM_CH  = 4;
  localparam int OVF_BIT = 0;
  localparam int CH_LSB  = 1;
  localparam int TRG_BIT = 6;
  localparam int RCP_LSB = 9;
  localparam int ADDR_STS = 0;
  localparam int ADDR_EN  = 1;

  // Bits of the enable word that exist (and of the flags routed to irq)
  function automatic logic [STS_W-1:0] irq_src_mask();
    logic [STS_W-1:0] m;
    m = '0;
    m[OVF_BIT] = 1'b1;
    m[TRG_BIT] = 1'b1;
    for (int i = 0; i < NUM_CH; i++) m[CH_LSB+i] = 1'b1;
    return m;
  endfunction

  // Bits of the status word that exist
  function automatic logic [STS_W-1:0] status_mask();
    logic [STS_W-1:0] m;
    m = irq_src_mask();
    for (int i = 0; i < NUM_CH; i++) m[RCP_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_sticky_bit.sv
// One sticky flag: hardware set has priority over clear.
module tmr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_trig_edge.sv
// Finds the qualifying edge of the trigger level.
module tmr_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic falling_sel,
  input  logic any_edge,
  output logic trig_evt
);
  logic prev_q;
  logic rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= trig_in;
  end

  assign rise_w = trig_in & ~prev_q;
  assign fall_w = ~trig_in & prev_q;

  always_comb begin
    if (any_edge)         trig_evt = rise_w | fall_w;
    else if (falling_sel) trig_evt = fall_w;
    else                  trig_evt = rise_w;
  end
endmodule

// File: rtl/tmr_chan_flag.sv
// Event flag and overcapture flag of one channel.
module tmr_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic dat_rd_i,
  input  logic capture_mode_i,
  input  logic sw_clr_evt_i,
  input  logic sw_clr_rcp_i,
  output logic evt_flag_o,
  output logic rcp_flag_o
);
  logic clr_evt_w;
  logic rcp_set_w;

  // a capture-data read acknowledges only in capture mode
  assign clr_evt_w = sw_clr_evt_i | (capture_mode_i & dat_rd_i);
  // overcapture only when the pending flag is not being acknowledged now
  assign rcp_set_w = evt_i & capture_mode_i & evt_flag_o & ~clr_evt_w;

  tmr_sticky_bit u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr_evt_w), .q_o(evt_flag_o)
  );

  tmr_sticky_bit u_rcp (
    .clk(clk), .rst_n(rst_n), .set_i(rcp_set_w), .clr_i(sw_clr_rcp_i), .q_o(rcp_flag_o)
  );
endmodule

// File: rtl/tmr_irq_regs.sv
// Bus decode, enable word, read mux and interrupt combine.
module tmr_irq_regs #(
  parameter int ADDR_W = 2,
  parameter int STS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [STS_W-1:0]  status_i,
  output logic [STS_W-1:0]  sw_clr_o,
  output logic [STS_W-1:0]  en_o,
  output logic [STS_W-1:0]  rdata_o,
  output logic              irq_o
);
  import tmr_irq_pkg::*;

  localparam logic [STS_W-1:0]  EN_MASK  = STS_W'(irq_src_mask());
  localparam logic [ADDR_W-1:0] A_STS    = ADDR_W'(ADDR_STS);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(ADDR_EN);

  logic sel_sts, sel_en;

  assign sel_sts  = (bus_addr == A_STS);
  assign sel_en   = (bus_addr == A_EN);
  assign sw_clr_o = (bus_wr && sel_sts) ? ~bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_o <= '0;
    else if (bus_wr && sel_en) en_o <= bus_wdata & EN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else if (bus_rd) begin
      if (sel_sts)     rdata_o <= status_i;
      else if (sel_en) rdata_o <= en_o;
      else             rdata_o <= '0;
    end
  end

  assign irq_o = |(status_i & en_o & EN_MASK);
endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status #(
  parameter int ADDR_W = 2,
  parameter int NUM_CH = 4,
  parameter int STS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [STS_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] ch_evt,
  input  logic [NUM_CH-1:0] ch_dat_rd,
  input  logic [NUM_CH-1:0] ch_capture_mode,
  input  logic              ovf_evt,
  input  logic              sw_ovf_req,
  input  logic              trig_reinit,
  input  logic              ovf_gen_en,
  input  logic              ovf_src_restrict,
  input  logic              trig_in,
  input  logic              trig_falling,
  input  logic              trig_suspend,
  output logic              irq
);
  import tmr_irq_pkg::*;

  logic [STS_W-1:0]  status_w;
  logic [STS_W-1:0]  en_w;
  logic [STS_W-1:0]  sw_clr_w;
  logic [NUM_CH-1:0] evt_flag_w;
  logic [NUM_CH-1:0] rcp_flag_w;
  logic              ovf_flag_w, trg_flag_w;
  logic              ovf_set_w, trg_evt_w;

  assign ovf_set_w = ovf_evt |
                     ((sw_ovf_req | trig_reinit) & ovf_gen_en & ~ovf_src_restrict);

  tmr_sticky_bit u_ovf (
    .clk(clk), .rst_n(rst_n), .set_i(ovf_set_w), .clr_i(sw_clr_w[OVF_BIT]), .q_o(ovf_flag_w)
  );

  tmr_trig_edge u_trig_edge (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .falling_sel(trig_falling),
    .any_edge(trig_suspend), .trig_evt(trg_evt_w)
  );

  tmr_sticky_bit u_trg (
    .clk(clk), .rst_n(rst_n), .set_i(trg_evt_w), .clr_i(sw_clr_w[TRG_BIT]), .q_o(trg_flag_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_chan_flag u_chan (
      .clk(clk), .rst_n(rst_n),
      .evt_i(ch_evt[c]), .dat_rd_i(ch_dat_rd[c]), .capture_mode_i(ch_capture_mode[c]),
      .sw_clr_evt_i(sw_clr_w[CH_LSB+c]), .sw_clr_rcp_i(sw_clr_w[RCP_LSB+c]),
      .evt_flag_o(evt_flag_w[c]), .rcp_flag_o(rcp_flag_w[c])
    );
  end

  always_comb begin
    status_w          = '0;
    status_w[OVF_BIT] = ovf_flag_w;
    status_w[TRG_BIT] = trg_flag_w;
    for (int c = 0; c < NUM_CH; c++) begin
      status_w[CH_LSB+c]  = evt_flag_w[c];
      status_w[RCP_LSB+c] = rcp_flag_w[c];
    end
  end

  tmr_irq_regs #(.ADDR_W(ADDR_W), .STS_W(STS_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .status_i(status_w), .sw_clr_o(sw_clr_w), .en_o(en_w),
    .rdata_o(bus_rdata), .irq_o(irq)
  );
endmodule

// File: rtl/tmr_irq_status_chk.sv
module tmr_irq_status_chk #(
  parameter int ADDR_W = 2,
  parameter int NUM_CH = 4,
  parameter int STS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [STS_W-1:0]  bus_wdata,
  input logic              bus_wr,
  input logic [STS_W-1:0]  bus_rdata,
  input logic [NUM_CH-1:0] ch_evt,
  input logic [NUM_CH-1:0] ch_dat_rd,
  input logic [NUM_CH-1:0] ch_capture_mode,
  input logic [STS_W-1:0]  sts,
  input logic [STS_W-1:0]  en,
  input logic              irq
);
  logic sts_wr;
  assign sts_wr = bus_wr && (bus_addr == '0);

  // R2: reserved bit positions never read back as 1
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 16'hE1A0) == '0);

  // R3: a written 1 never clears a flag (no data read in that cycle)
  assert_write_one_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && ch_dat_rd == '0) |=>
      ((sts & $past(sts & bus_wdata)) == $past(sts & bus_wdata)));

  // R8: overflow flag stays set unless software writes 0 to it
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !(sts_wr && !bus_wdata[0])) |=> sts[0]);

  // R10: no enabled source flag means no request
  assert_irq_needs_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & 16'h005F) == '0 || en == '0) |-> !irq);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4: an event always leaves the channel flag set
    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_evt[c] |=> sts[1+c]);

    // R5: compare-mode data read does not clear the flag
    assert_cmp_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_capture_mode[c] && ch_dat_rd[c] && sts[1+c] && !(sts_wr && !bus_wdata[1+c]))
        |=> sts[1+c]);

    // R6: unacknowledged second capture sets overcapture
    assert_recap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_evt[c] && ch_capture_mode[c] && sts[1+c] && !ch_dat_rd[c] &&
       !(sts_wr && !bus_wdata[1+c])) |=> sts[9+c]);
  end
endmodule

bind tmr_irq_status tmr_irq_status_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .STS_W(STS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .ch_evt(ch_evt), .ch_dat_rd(ch_dat_rd),
  .ch_capture_mode(ch_capture_mode), .sts(status_w), .en(en_w), .irq(irq)
);

// File: tb/test_tmr_irq_status.sv
`timescale 1ns/1ps
module test_tmr_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic [3:0]  ch_evt = '0, ch_dat_rd = '0, ch_capture_mode = 4'b1101;
  logic        ovf_evt = 0, sw_ovf_req = 0, trig_reinit = 0;
  logic        ovf_gen_en = 0, ovf_src_restrict = 0;
  logic        trig_in = 0, trig_falling = 0, trig_suspend = 0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  tmr_irq_status i_tmr_irq_status (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ch_evt(ch_evt), .ch_dat_rd(ch_dat_rd), .ch_capture_mode(ch_capture_mode),
    .ovf_evt(ovf_evt), .sw_ovf_req(sw_ovf_req), .trig_reinit(trig_reinit),
    .ovf_gen_en(ovf_gen_en), .ovf_src_restrict(ovf_src_restrict),
    .trig_in(trig_in), .trig_falling(trig_falling), .trig_suspend(trig_suspend),
    .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_sts = '0, m_en = '0, m_rd = '0;
  logic        m_prev = 1'b0;

  always @(posedge clk) begin : model
    logic [15:0] clr, nxt;
    logic rise, fall, tev, oset;
    if (!rst_n) begin
      m_sts = '0; m_en = '0; m_rd = '0; m_prev = 1'b0;
    end else begin
      clr  = (bus_wr && bus_addr == 2'd0) ? ~bus_wdata : 16'h0;
      nxt  = m_sts;
      rise = trig_in && !m_prev;
      fall = !trig_in && m_prev;
      tev  = trig_suspend ? (rise || fall) : (trig_falling ? fall : rise);
      oset = ovf_evt || ((sw_ovf_req || trig_reinit) && ovf_gen_en && !ovf_src_restrict);
      if (oset) nxt[0] = 1; else if (clr[0]) nxt[0] = 0;
      if (tev)  nxt[6] = 1; else if (clr[6]) nxt[6] = 0;
      for (int c = 0; c < 4; c++) begin
        bit ack;
        ack = clr[1+c] || (ch_capture_mode[c] && ch_dat_rd[c]);
        if (ch_evt[c]) nxt[1+c] = 1; else if (ack) nxt[1+c] = 0;
        if (ch_evt[c] && ch_capture_mode[c] && m_sts[1+c] && !ack) nxt[9+c] = 1;
        else if (clr[9+c]) nxt[9+c] = 0;
      end
      if (bus_rd) m_rd = (bus_addr == 2'd0) ? m_sts : (bus_addr == 2'd1) ? m_en : 16'h0;
      if (bus_wr && bus_addr == 2'd1) m_en = bus_wdata & 16'h005F;
      m_sts  = nxt;
      m_prev = trig_in;
    end
  end

  // per-cycle comparison against the model (R10, R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (irq !== |(m_sts & m_en & 16'h005F)) begin
        n_fail++;
        $display("FAIL R10 irq act=%0b exp=%0b t=%0t", irq, |(m_sts & m_en & 16'h005F), $time);
      end
      n_tests++;
      if (bus_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R11 rdata act=%h exp=%h t=%0t", bus_rdata, m_rd, $time);
      end
    end
  end

  // ---------------- helpers (start and end on a falling edge) ----------------
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic pch(input logic [3:0] e, input logic [3:0] r);
    ch_evt = e; ch_dat_rd = r;
    @(negedge clk);
    ch_evt = 0; ch_dat_rd = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all R) act=running exp=finished");
    summary();
  end

  initial begin : stim
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1
    rd(2'd0, v); chk("R1 status after reset", v, 16'h0000);
    rd(2'd1, v); chk("R1 enable after reset", v, 16'h0000);
    chk("R1 irq after reset", {15'b0, irq}, 16'h0);
    // R2 / R3
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R3 write ones no effect", v, 16'h0000);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R2 enable reserved zero", v, 16'h005F);
    // R4 / R10
    pch(4'b0001, 4'b0000); rd(2'd0, v); chk("R4 capture sets ch0", v, 16'h0002);
    chk("R10 irq enabled flag", {15'b0, irq}, 16'h0001);
    // R6
    pch(4'b0001, 4'b0000); rd(2'd0, v); chk("R6 overcapture ch0", v, 16'h0202);
    // R3 clear by zero
    wr(2'd0, 16'hFDFD); rd(2'd0, v); chk("R3 write zero clears", v, 16'h0000);
    // R5 compare mode
    pch(4'b0010, 4'b0000); rd(2'd0, v); chk("R4 compare sets ch1", v, 16'h0004);
    pch(4'b0000, 4'b0010); rd(2'd0, v); chk("R5 compare read keeps", v, 16'h0004);
    pch(4'b0010, 4'b0000); rd(2'd0, v); chk("R6 compare no overcapture", v, 16'h0004);
    wr(2'd0, 16'h0000);
    // R5 capture mode read clears
    pch(4'b0100, 4'b0000); rd(2'd0, v); chk("R4 capture sets ch2", v, 16'h0008);
    pch(4'b0000, 4'b0100); rd(2'd0, v); chk("R5 capture read clears", v, 16'h0000);
    // R6 read + capture same cycle
    pch(4'b1000, 4'b0000);
    pch(4'b1000, 4'b1000); rd(2'd0, v); chk("R6 read with capture", v, 16'h0010);
    // R9 set beats zero write
    ch_evt = 4'b1000; wr(2'd0, 16'h0000); ch_evt = 0;
    rd(2'd0, v); chk("R9 set wins", v, 16'h0010);
    wr(2'd0, 16'h0000); rd(2'd0, v); chk("R3 clear all", v, 16'h0000);
    // R7 trigger
    trig_in = 1; step(); rd(2'd0, v); chk("R7 rising edge", v, 16'h0040);
    chk("R10 irq trigger", {15'b0, irq}, 16'h0001);
    wr(2'd0, 16'h0000);
    trig_in = 0; step(); rd(2'd0, v); chk("R7 falling ignored", v, 16'h0000);
    trig_falling = 1;
    trig_in = 1; step(); rd(2'd0, v); chk("R7 rising ignored", v, 16'h0000);
    trig_in = 0; step(); rd(2'd0, v); chk("R7 falling edge", v, 16'h0040);
    wr(2'd0, 16'h0000);
    trig_suspend = 1;
    trig_in = 1; step(); rd(2'd0, v); chk("R7 suspend rise", v, 16'h0040);
    wr(2'd0, 16'h0000);
    trig_in = 0; step(); rd(2'd0, v); chk("R7 suspend fall", v, 16'h0040);
    wr(2'd0, 16'h0000);
    trig_suspend = 0; trig_falling = 0;
    // R8 overflow
    sw_ovf_req = 1; step(); sw_ovf_req = 0;
    rd(2'd0, v); chk("R8 sw req gen off", v, 16'h0000);
    ovf_gen_en = 1; ovf_src_restrict = 1;
    sw_ovf_req = 1; step(); sw_ovf_req = 0;
    rd(2'd0, v); chk("R8 sw req restricted", v, 16'h0000);
    ovf_src_restrict = 0;
    sw_ovf_req = 1; step(); sw_ovf_req = 0;
    rd(2'd0, v); chk("R8 sw req allowed", v, 16'h0001);
    wr(2'd0, 16'h0000);
    trig_reinit = 1; step(); trig_reinit = 0;
    rd(2'd0, v); chk("R8 reinit allowed", v, 16'h0001);
    wr(2'd0, 16'h0000);
    ovf_gen_en = 0;
    ovf_evt = 1; step(); ovf_evt = 0;
    rd(2'd0, v); chk("R8 counter overflow", v, 16'h0001);
    wr(2'd0, 16'h0000);
    // R10 overcapture alone gives no irq
    pch(4'b0001, 4'b0000); pch(4'b0001, 4'b0000);
    wr(2'd0, 16'hFFFD); rd(2'd0, v); chk("R6 overcapture only", v, 16'h0200);
    chk("R10 overcapture no irq", {15'b0, irq}, 16'h0000);
    wr(2'd1, 16'h0000);
    pch(4'b0001, 4'b0000);
    chk("R10 disabled no irq", {15'b0, irq}, 16'h0000);
    wr(2'd1, 16'h0002);
    chk("R10 enable raises irq", {15'b0, irq}, 16'h0001);
    rd(2'd1, v); chk("R11 enable readback", v, 16'h0002);
    // R11 unused addresses
    rd(2'd2, v); chk("R11 addr 2 zero", v, 16'h0000);
    rd(2'd3, v); chk("R11 addr 3 zero", v, 16'h0000);
    step();
    summary();
  end
endmodule